// File: doc/BRIEF.md
# Character Attribute Renderer

This block decides, for each of four character positions, what the display shows at that moment. A position can show its stored character, a cursor, or nothing. The cursor is a cell with every dot lit at half brightness. The inputs are the four stored character words, the global control word and a blink phase from an outside timebase. For each position the block produces a display mode, a brightness class (normal or half) and the character code, lined up with the mode so that a downstream glyph lookup can use them.

A position takes a per-character attribute only when two bits are both set: the global attribute-enable bit in the control word and the top bit of that position's own character word. The attribute selector then picks one of four behaviours. The first shows a steady cursor. The second blinks the character. The third blinks a cursor. The fourth alternates between the character and the cursor.

Three global functions sit above the attributes:
- Lamp test lights every cell at half brightness.
- A zero brightness code blanks the whole display.
- Whole-display blink darkens every position during the off phase of the blink.

The block holds no state apart from one output register. Clearing a control bit therefore brings back the earlier picture at once.

Top module: `char_attr_render`

## Requirements
- R1: While rstN is low, every posMode field is 00 (off), every posHalf bit is 0 and posGlyph is all zeros.
- R2: Outputs pass through exactly one register. A change on any input shows at the outputs after the next rising clock edge and not before.
- R3: The posMode encoding is 00 = off, 01 = character, 10 = cursor. Position i uses posMode[2i+1:2i]. A position shows its character (01) when all of the following hold: lamp test is clear, the brightness code is non-zero, the display is not in a whole-display blink off phase, and either attribute enable (control bit 4) is 0 or the position's word bit 7 is 0.
- R4: Attribute code 00 in control bits 3:2 shows a steady cursor (10) on every position that has attributes active.
- R5: Attribute code 01 shows the character (01) when blinkPhase is 1 and off (00) when blinkPhase is 0.
- R6: Attribute code 10 shows the cursor (10) when blinkPhase is 1 and off (00) when blinkPhase is 0.
- R7: Attribute code 11 shows the character (01) when blinkPhase is 1 and the cursor (10) when blinkPhase is 0.
- R8: With control bit 5 set, every position is off (00) while blinkPhase is 0, whatever its bit 7 is. While blinkPhase is 1, the other rules decide the output.
- R9: Lamp test (control bit 6) makes every position a cursor (10). It overrides the brightness code, the whole-display blink and the attributes.
- R10: Brightness code 00 in control bits 1:0 turns every position off (00) unless lamp test is set.
- R11: posHalf[i] is 1 exactly when position i is in cursor mode. posMode never takes the value 11.
- R12: Attributes do not change the stored text. Clearing attribute enable returns every position to character mode, showing its code unchanged.
- R13: posGlyph[7i+6:7i] carries bits 6:0 of position i's character word, with the same one-cycle latency as the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charWords | input | 32 | Four stored character words. Position i is at [8i+7:8i] and bit 7 of each word is its attribute flag |
| ctrlWord | input | 8 | Control word. Bits 1:0 brightness, 3:2 attribute selector, 4 attribute enable, 5 whole-display blink, 6 lamp test; bit 7 is not used here |
| blinkPhase | input | 1 | Blink timebase phase: 1 = visible phase, 0 = dark phase |
| posMode | output | 8 | Registered display mode per position, 2 bits each |
| posHalf | output | 4 | Registered half-brightness class per position |
| posGlyph | output | 28 | Registered 7-bit character code per position |

## Verification
The hardest case to reach is a mixed display: some positions carry attributes and others do not, so each position has to be told apart in the same output word. The stimulus flags only one or two positions with bit 7. It then steps through every attribute code in both blink phases and checks each position's field against the spec. The same flagged text is then run under lamp test, under zero brightness and under whole-display blink. This shows that the higher-priority functions override the attributes, and a final step clears attribute enable to show that the text comes back unchanged.

// File: rtl/char_attr_render_pkg.sv
package char_attr_render_pkg;

  localparam int CTRL_W      = 8;
  localparam int BRIGHT_LSB  = 0;
  localparam int ATTR_LSB    = 2;
  localparam int ATTR_EN_BIT = 4;
  localparam int BLINK_BIT   = 5;
  localparam int LAMP_BIT    = 6;
  localparam int CLEAR_BIT   = 7;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_CHAR   = 2'b01,
    MODE_CURSOR = 2'b10
  } dispMode_e;

  typedef enum logic [1:0] {
    ATTR_CURSOR       = 2'b00,
    ATTR_BLINK_CHAR   = 2'b01,
    ATTR_BLINK_CURSOR = 2'b10,
    ATTR_ALTERNATE    = 2'b11
  } attrSel_e;

  // Strobes handed from the control decode to the per-position datapath
  typedef struct packed {
    logic     lampTest;
    logic     blankAll;
    logic     globalDark;
    logic     attrEnable;
    attrSel_e attrSel;
    logic     phaseOn;
  } renderStrobes_t;

endpackage

// File: rtl/char_attr_render_ctrl.sv
module char_attr_render_ctrl
  import char_attr_render_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              blinkPhase,
  output renderStrobes_t    strobes
);

  // The clear bit acts on the character store, which is outside this block
  logic unusedClearBit;
  assign unusedClearBit = ctrlWord[CLEAR_BIT];

  always_comb begin
    strobes.lampTest   = ctrlWord[LAMP_BIT];
    strobes.blankAll   = (ctrlWord[BRIGHT_LSB +: 2] == 2'b00);
    strobes.globalDark = ctrlWord[BLINK_BIT] & ~blinkPhase;
    strobes.attrEnable = ctrlWord[ATTR_EN_BIT];
    strobes.attrSel    = attrSel_e'(ctrlWord[ATTR_LSB +: 2]);
    strobes.phaseOn    = blinkPhase;
  end

endmodule

// File: rtl/char_attr_render_dp.sv
module char_attr_render_dp
  import char_attr_render_pkg::*;
#(
  parameter int NUM_POS = 4,
  parameter int CHAR_W  = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_POS*CHAR_W-1:0]      charWords,
  input  renderStrobes_t                 strobes,
  output logic [NUM_POS*2-1:0]           posMode,
  output logic [NUM_POS-1:0]             posHalf,
  output logic [NUM_POS*(CHAR_W-1)-1:0]  posGlyph
);

  localparam int CODE_W   = CHAR_W - 1;
  localparam int FLAG_BIT = CHAR_W - 1;

  for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
    dispMode_e         nextMode;
    dispMode_e         modeQ;
    logic [CODE_W-1:0] glyphQ;
    logic              attrActive;

    assign attrActive = strobes.attrEnable & charWords[p*CHAR_W + FLAG_BIT];

    // Priority: lamp test, blank brightness, global dark phase, attribute, normal
    always_comb begin
      if (strobes.lampTest) begin
        nextMode = MODE_CURSOR;
      end else if (strobes.blankAll || strobes.globalDark) begin
        nextMode = MODE_OFF;
      end else if (attrActive) begin
        unique case (strobes.attrSel)
          ATTR_CURSOR:       nextMode = MODE_CURSOR;
          ATTR_BLINK_CHAR:   nextMode = strobes.phaseOn ? MODE_CHAR : MODE_OFF;
          ATTR_BLINK_CURSOR: nextMode = strobes.phaseOn ? MODE_CURSOR : MODE_OFF;
          ATTR_ALTERNATE:    nextMode = strobes.phaseOn ? MODE_CHAR : MODE_CURSOR;
          default:           nextMode = MODE_CHAR;
        endcase
      end else begin
        nextMode = MODE_CHAR;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ  <= MODE_OFF;
        glyphQ <= '0;
      end else begin
        modeQ  <= nextMode;
        glyphQ <= charWords[p*CHAR_W +: CODE_W];
      end
    end

    assign posMode[p*2 +: 2]          = modeQ;
    assign posHalf[p]                 = (modeQ == MODE_CURSOR);
    assign posGlyph[p*CODE_W +: CODE_W] = glyphQ;
  end

endmodule

// File: rtl/char_attr_render.sv
module char_attr_render
  import char_attr_render_pkg::*;
#(
  parameter int NUM_POS = 4,
  parameter int CHAR_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_POS*CHAR_W-1:0]     charWords,
  input  logic [CTRL_W-1:0]             ctrlWord,
  input  logic                          blinkPhase,
  output logic [NUM_POS*2-1:0]          posMode,
  output logic [NUM_POS-1:0]            posHalf,
  output logic [NUM_POS*(CHAR_W-1)-1:0] posGlyph
);

  renderStrobes_t strobes;

  char_attr_render_ctrl u_ctrl (
    .ctrlWord   (ctrlWord),
    .blinkPhase (blinkPhase),
    .strobes    (strobes)
  );

  char_attr_render_dp #(
    .NUM_POS (NUM_POS),
    .CHAR_W  (CHAR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .charWords (charWords),
    .strobes   (strobes),
    .posMode   (posMode),
    .posHalf   (posHalf),
    .posGlyph  (posGlyph)
  );

endmodule

// File: rtl/char_attr_render_chk.sv
module char_attr_render_chk
  import char_attr_render_pkg::*;
#(
  parameter int NUM_POS = 4,
  parameter int CHAR_W  = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_POS*CHAR_W-1:0]     charWords,
  input logic [CTRL_W-1:0]             ctrlWord,
  input logic                          blinkPhase,
  input logic [NUM_POS*2-1:0]          posMode,
  input logic [NUM_POS-1:0]            posHalf,
  input logic [NUM_POS*(CHAR_W-1)-1:0] posGlyph
);

  localparam int CODE_W = CHAR_W - 1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (posMode == '0 && posHalf == '0 && posGlyph == '0));

  // R9
  lamp_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[LAMP_BIT] |=> (posHalf == '1));

  // R10
  blank_bright_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWord[LAMP_BIT] && ctrlWord[1:0] == 2'b00) |=> (posMode == '0));

  // R8
  global_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWord[LAMP_BIT] && ctrlWord[BLINK_BIT] && !blinkPhase) |=> (posMode == '0));

  for (genvar p = 0; p < NUM_POS; p++) begin : g_chk
    // R11
    half_matches_cursor_chk: assert property (@(posedge clk) disable iff (!rstN)
      (posMode[p*2 +: 2] != 2'b11) && (posHalf[p] == (posMode[p*2 +: 2] == 2'b10)));

    // R3
    plain_char_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrlWord[LAMP_BIT] && ctrlWord[1:0] != 2'b00
       && !(ctrlWord[BLINK_BIT] && !blinkPhase)
       && !(ctrlWord[ATTR_EN_BIT] && charWords[p*CHAR_W + CHAR_W-1]))
      |=> (posMode[p*2 +: 2] == 2'b01));

    // R13
    glyph_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      rstN |=> (posGlyph[p*CODE_W +: CODE_W] == $past(charWords[p*CHAR_W +: CODE_W])));
  end

endmodule

bind char_attr_render char_attr_render_chk #(
  .NUM_POS (NUM_POS),
  .CHAR_W  (CHAR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .charWords  (charWords),
  .ctrlWord   (ctrlWord),
  .blinkPhase (blinkPhase),
  .posMode    (posMode),
  .posHalf    (posHalf),
  .posGlyph   (posGlyph)
);

// File: tb/tb_char_attr_render.sv
module tb_char_attr_render;

  localparam int NUM_POS = 4;
  localparam int CHAR_W  = 8;

  // Text with no attribute flags, with the position-1 flag, and with the position-3 and position-1 flags
  localparam logic [31:0] TXT_PLAIN = 32'h5354_4F50;
  localparam logic [31:0] TXT_ONE   = 32'h5354_CF50;
  localparam logic [31:0] TXT_TWO   = 32'hD354_CF50;
  localparam logic [27:0] GLYPHS    = {7'h53, 7'h54, 7'h4F, 7'h50};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] charWords = TXT_PLAIN;
  logic [7:0]  ctrlWord = 8'h03;
  logic        blinkPhase = 1'b1;
  logic [7:0]  posMode;
  logic [3:0]  posHalf;
  logic [27:0] posGlyph;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  char_attr_render #(.NUM_POS(NUM_POS), .CHAR_W(CHAR_W)) dut (
    .clk(clk), .rstN(rstN), .charWords(charWords), .ctrlWord(ctrlWord),
    .blinkPhase(blinkPhase), .posMode(posMode), .posHalf(posHalf), .posGlyph(posGlyph)
  );

  initial forever #4 clk = ~clk;

  function automatic logic [3:0] halfOf(input logic [7:0] m);
    logic [3:0] h;
    for (int i = 0; i < 4; i++) h[i] = (m[i*2 +: 2] == 2'b10);
    return h;
  endfunction

  task automatic checkMode(input string req, input logic [7:0] expMode);
    checks++;
    if (posMode !== expMode) begin
      errors++;
      $display("FAIL %s posMode actual=%h expected=%h", req, posMode, expMode);
    end
    checks++;
    if (posHalf !== halfOf(expMode)) begin
      errors++;
      $display("FAIL %s posHalf actual=%b expected=%b (R11)", req, posHalf, halfOf(expMode));
    end
  endtask

  task automatic drive(input logic [7:0] c, input logic [31:0] w, input logic ph,
                       input string req, input logic [7:0] expMode);
    @(negedge clk);
    ctrlWord = c; charWords = w; blinkPhase = ph;
    @(negedge clk);
    checkMode(req, expMode);
  endtask

  task automatic testReset();
    repeat (2) @(negedge clk);
    checkMode("R1", 8'h00);
    checks++;
    if (posGlyph !== 28'h0) begin
      errors++;
      $display("FAIL R1 posGlyph actual=%h expected=0", posGlyph);
    end
    rstN = 1'b1;
  endtask

  task automatic testNormal();
    drive(8'h03, TXT_PLAIN, 1'b1, "R3 plain", 8'h55);
    checks++;
    if (posGlyph !== GLYPHS) begin
      errors++;
      $display("FAIL R13 posGlyph actual=%h expected=%h", posGlyph, GLYPHS);
    end
    drive(8'h03, TXT_PLAIN, 1'b0, "R3 dark phase no blink", 8'h55);
    drive(8'h0B, TXT_TWO, 1'b0, "R3 flags without enable", 8'h55);
    checks++;
    if (posGlyph !== GLYPHS) begin
      errors++;
      $display("FAIL R13 flag stripped actual=%h expected=%h", posGlyph, GLYPHS);
    end
  endtask

  task automatic testLatency();
    drive(8'h03, TXT_PLAIN, 1'b1, "R2 setup", 8'h55);
    @(negedge clk);
    ctrlWord = 8'h00;
    #1;
    checkMode("R2 before edge", 8'h55);
    @(negedge clk);
    checkMode("R2 after edge", 8'h00);
  endtask

  task automatic testAttributes();
    drive(8'h13, TXT_ONE, 1'b1, "R4 cursor", 8'h59);
    drive(8'h13, TXT_ONE, 1'b0, "R4 cursor dark", 8'h59);
    drive(8'h17, TXT_ONE, 1'b1, "R5 blink char on", 8'h55);
    drive(8'h17, TXT_ONE, 1'b0, "R5 blink char off", 8'h51);
    drive(8'h17, TXT_TWO, 1'b0, "R5 two flags off", 8'h11);
    drive(8'h1B, TXT_ONE, 1'b1, "R6 blink cursor on", 8'h59);
    drive(8'h1B, TXT_ONE, 1'b0, "R6 blink cursor off", 8'h51);
    drive(8'h1F, TXT_ONE, 1'b1, "R7 alternate on", 8'h55);
    drive(8'h1F, TXT_TWO, 1'b0, "R7 alternate off", 8'h99);
  endtask

  task automatic testGlobal();
    drive(8'h23, TXT_PLAIN, 1'b0, "R8 whole blink dark", 8'h00);
    drive(8'h23, TXT_PLAIN, 1'b1, "R8 whole blink lit", 8'h55);
    drive(8'h37, TXT_ONE, 1'b0, "R8 dark over attribute", 8'h00);
    drive(8'h33, TXT_ONE, 1'b1, "R8 lit keeps attribute", 8'h59);
    drive(8'h10, TXT_ONE, 1'b1, "R10 zero brightness", 8'h00);
    drive(8'h00, TXT_PLAIN, 1'b1, "R10 zero brightness plain", 8'h00);
    drive(8'h40, TXT_PLAIN, 1'b1, "R9 lamp over blank", 8'hAA);
    drive(8'h7F, TXT_TWO, 1'b0, "R9 lamp over all", 8'hAA);
    drive(8'h03, TXT_PLAIN, 1'b1, "R9 lamp released", 8'h55);
  endtask

  task automatic testRestore();
    drive(8'h13, TXT_TWO, 1'b1, "R12 cursors shown", 8'h99);
    drive(8'h03, TXT_TWO, 1'b1, "R12 enable cleared", 8'h55);
    checks++;
    if (posGlyph !== GLYPHS) begin
      errors++;
      $display("FAIL R12 text actual=%h expected=%h", posGlyph, GLYPHS);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testNormal();
    testLatency();
    testAttributes();
    testGlobal();
    testRestore();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule